// File: doc/BRIEF.md
# Flash Host Interrupt Unit

This block collects the interrupt conditions of a serial flash host controller and presents them to software through four registers that share one bit layout: a latched status word, a write-one-to-set enable port, a write-one-to-clear disable port and a read-only view of the resulting mask. It also owns the two FIFO watermark registers that turn FIFO occupancy counts into level-type conditions. The FIFOs are not part of the block: their fill levels arrive as counts, and their overflow and underflow events arrive as single-cycle pulses.

Software arms the sources it cares about by writing ones to the enable port and disarms them through the disable port, so no read-modify-write of the mask is ever needed. It acknowledges an event by writing ones to the status register. The single interrupt line is a registered level that stays high while any latched and armed status bit remains.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, the overflow and underflow bits are 0, the TX watermark reads 1, the RX watermark reads 32 and the interrupt output is 0.
- R2: Register offsets are status 0x04, enable 0x08, disable 0x0C, mask 0x10, TX watermark 0x28 and RX watermark 0x2C. Status and mask bits are 0 RX overflow, 2 TX below watermark, 3 TX full, 4 RX at watermark, 5 RX full and 6 TX underflow. Bit 1 and bits 7 and up always read 0, and reads of the enable and disable offsets return 0.
- R3: A write to the enable offset sets every defined mask bit that is 1 in the write data and leaves the other mask bits unchanged.
- R4: A write to the disable offset clears every mask bit that is 1 in the write data and leaves the other mask bits unchanged.
- R5: Status bit 2 is set on the clock edge after the TX count is strictly less than the TX watermark. With a watermark of 1 this means the TX FIFO is empty.
- R6: Status bit 3 is set when the TX count is at least the FIFO depth. Status bit 5 is set when the RX count is at least the FIFO depth.
- R7: Status bit 4 is set when the RX count is at least the RX watermark.
- R8: An RX overflow pulse sets status bit 0 and a TX underflow pulse sets status bit 6. Each bit then holds until a status write clears it. A pulse in the same cycle as a clear of its bit leaves the bit set.
- R9: Writing ones to the status offset clears those latched bits. A level bit whose condition still holds reads as set again after that write. A level bit stays latched after its condition goes away until it is cleared.
- R10: The interrupt output equals the OR over all bits of status AND mask, delayed by one clock.
- R11: Each watermark register holds the low count-width bits of the last value written to it and reads them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| tx_level | input | CNT_W | Current TX FIFO entry count |
| rx_level | input | CNT_W | Current RX FIFO entry count |
| rx_ovf_pulse | input | 1 | Single-cycle RX overflow event |
| tx_udf_pulse | input | 1 | Single-cycle TX underflow event |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with a FIFO depth of 40, which keeps the count width at six bits while keeping the reset RX watermark of 32 below the full mark. Every watermark value from 0 to 41 is swept against every count from 0 to 40 on both FIFO sides. This covers the strict-less-than and at-or-above edges, the zero watermark and the beyond-depth watermark. All 128 patterns of the low seven data bits are applied to both the enable and the disable port. The interrupt line is checked bit by bit, including its one-cycle lag and the undefined bit 1.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

  localparam int unsigned IRQ_W = 7;

  localparam int unsigned BIT_RX_OVF   = 0;
  localparam int unsigned BIT_TX_LOW   = 2;
  localparam int unsigned BIT_TX_FULL  = 3;
  localparam int unsigned BIT_RX_AVAIL = 4;
  localparam int unsigned BIT_RX_FULL  = 5;
  localparam int unsigned BIT_TX_UDF   = 6;

  localparam logic [IRQ_W-1:0] IRQ_DEFINED = 7'b111_1101;

  localparam logic [7:0] OFF_STATUS = 8'h04;
  localparam logic [7:0] OFF_ARM    = 8'h08;
  localparam logic [7:0] OFF_DISARM = 8'h0C;
  localparam logic [7:0] OFF_MASK   = 8'h10;
  localparam logic [7:0] OFF_TX_WM  = 8'h28;
  localparam logic [7:0] OFF_RX_WM  = 8'h2C;

  typedef struct packed {
    logic st_clr;
    logic mask_set;
    logic mask_clr;
    logic tx_wm_wr;
    logic rx_wm_wr;
  } wr_strobe_t;

endpackage

// File: rtl/flash_irq_rst_sync.sv
module flash_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/flash_irq_regif.sv
module flash_irq_regif
  import flash_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IRQ_W-1:0]  status,
  input  logic [IRQ_W-1:0]  mask,
  input  logic [CNT_W-1:0]  tx_wm,
  input  logic [CNT_W-1:0]  rx_wm,
  output wr_strobe_t        strobe,
  output logic [DATA_W-1:0] rdata
);
  logic hit_status, hit_arm, hit_disarm, hit_mask, hit_tx_wm, hit_rx_wm;

  always_comb begin
    hit_status = (addr == ADDR_W'(OFF_STATUS));
    hit_arm    = (addr == ADDR_W'(OFF_ARM));
    hit_disarm = (addr == ADDR_W'(OFF_DISARM));
    hit_mask   = (addr == ADDR_W'(OFF_MASK));
    hit_tx_wm  = (addr == ADDR_W'(OFF_TX_WM));
    hit_rx_wm  = (addr == ADDR_W'(OFF_RX_WM));
  end

  always_comb begin
    strobe.st_clr   = wr_en & hit_status;
    strobe.mask_set = wr_en & hit_arm;
    strobe.mask_clr = wr_en & hit_disarm;
    strobe.tx_wm_wr = wr_en & hit_tx_wm;
    strobe.rx_wm_wr = wr_en & hit_rx_wm;
  end

  // Write-only ports and unmapped offsets read as zero.
  always_comb begin
    rdata = '0;
    if (hit_status) rdata = DATA_W'(status);
    if (hit_mask)   rdata = DATA_W'(mask);
    if (hit_tx_wm)  rdata = DATA_W'(tx_wm);
    if (hit_rx_wm)  rdata = DATA_W'(rx_wm);
  end
endmodule

// File: rtl/flash_irq_wm_reg.sv
module flash_irq_wm_reg #(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] wm
);
  logic [CNT_W-1:0] wm_q;
  logic [CNT_W-1:0] wm_d;

  always_comb begin
    wm_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q <= CNT_W'(RST_VAL);
    end else if (wr_en) begin
      wm_q <= wm_d;
    end
  end

  assign wm = wm_q;
endmodule

// File: rtl/flash_irq_events.sv
module flash_irq_events
  import flash_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 63,
  parameter int unsigned CNT_W      = 6
) (
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_wm,
  input  logic [CNT_W-1:0] rx_wm,
  input  logic             rx_ovf_pulse,
  input  logic             tx_udf_pulse,
  output logic [IRQ_W-1:0] events
);
  localparam logic [CNT_W-1:0] FULL_MARK = CNT_W'(FIFO_DEPTH);

  always_comb begin
    events               = '0;
    events[BIT_RX_OVF]   = rx_ovf_pulse;
    events[BIT_TX_LOW]   = (tx_level < tx_wm);
    events[BIT_TX_FULL]  = (tx_level >= FULL_MARK);
    events[BIT_RX_AVAIL] = (rx_level >= rx_wm);
    events[BIT_RX_FULL]  = (rx_level >= FULL_MARK);
    events[BIT_TX_UDF]   = tx_udf_pulse;
  end
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import flash_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] events,
  input  logic             st_clr,
  input  logic             mask_set,
  input  logic             mask_clr,
  input  logic [IRQ_W-1:0] wbits,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  logic [IRQ_W-1:0] clr_bits, set_bits, drop_bits;

  always_comb begin
    clr_bits  = st_clr   ? wbits : '0;
    set_bits  = mask_set ? wbits : '0;
    drop_bits = mask_clr ? wbits : '0;
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    if (IRQ_DEFINED[i]) begin : g_live
      logic st_q, st_d, mk_q, mk_d;

      // An arriving event outranks a same-cycle acknowledge.
      always_comb begin
        st_d = events[i] | (st_q & ~clr_bits[i]);
        mk_d = (mk_q | set_bits[i]) & ~drop_bits[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= 1'b0;
          mk_q <= 1'b0;
        end else begin
          st_q <= st_d;
          mk_q <= mk_d;
        end
      end

      assign status[i] = st_q;
      assign mask[i]   = mk_q;
    end else begin : g_hole
      logic unused_hole;
      assign unused_hole = events[i] ^ clr_bits[i] ^ set_bits[i] ^ drop_bits[i];
      assign status[i]   = 1'b0;
      assign mask[i]     = 1'b0;
    end
  end

  logic irq_q, irq_d;

  always_comb begin
    irq_d = |(status & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import flash_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned FIFO_DEPTH = 63,
  parameter int unsigned TX_WM_RST  = 1,
  parameter int unsigned RX_WM_RST  = 32,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              rx_ovf_pulse,
  input  logic              tx_udf_pulse,
  output logic              irq
);
  localparam int unsigned USED_W = (CNT_W > IRQ_W) ? CNT_W : IRQ_W;

  logic             rst_sync_n;
  wr_strobe_t       strobe;
  logic [IRQ_W-1:0] status_q, mask_q, events;
  logic [CNT_W-1:0] tx_wm, rx_wm;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:USED_W];

  flash_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  flash_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .status(status_q),
    .mask  (mask_q),
    .tx_wm (tx_wm),
    .rx_wm (rx_wm),
    .strobe(strobe),
    .rdata (reg_rdata)
  );

  flash_irq_wm_reg #(.CNT_W(CNT_W), .RST_VAL(TX_WM_RST)) u_tx_wm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (strobe.tx_wm_wr),
    .wr_val(reg_wdata[CNT_W-1:0]),
    .wm    (tx_wm)
  );

  flash_irq_wm_reg #(.CNT_W(CNT_W), .RST_VAL(RX_WM_RST)) u_rx_wm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (strobe.rx_wm_wr),
    .wr_val(reg_wdata[CNT_W-1:0]),
    .wm    (rx_wm)
  );

  flash_irq_events #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_events (
    .tx_level    (tx_level),
    .rx_level    (rx_level),
    .tx_wm       (tx_wm),
    .rx_wm       (rx_wm),
    .rx_ovf_pulse(rx_ovf_pulse),
    .tx_udf_pulse(tx_udf_pulse),
    .events      (events)
  );

  flash_irq_status u_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .events  (events),
    .st_clr  (strobe.st_clr),
    .mask_set(strobe.mask_set),
    .mask_clr(strobe.mask_clr),
    .wbits   (reg_wdata[IRQ_W-1:0]),
    .status  (status_q),
    .mask    (mask_q),
    .irq     (irq)
  );
endmodule

// File: rtl/flash_irq_ctrl_chk.sv
module flash_irq_ctrl_chk
  import flash_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned FIFO_DEPTH = 63,
  parameter int unsigned CNT_W      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [CNT_W-1:0]  tx_level,
  input logic              rx_ovf_pulse,
  input logic [IRQ_W-1:0]  status_q,
  input logic [IRQ_W-1:0]  mask_q,
  input logic              irq
);
  logic wr_arm, wr_disarm, wr_status;
  assign wr_arm    = reg_wr_en && (reg_addr == ADDR_W'(OFF_ARM));
  assign wr_disarm = reg_wr_en && (reg_addr == ADDR_W'(OFF_DISARM));
  assign wr_status = reg_wr_en && (reg_addr == ADDR_W'(OFF_STATUS));

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & mask_q)) |=> irq);  // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(status_q & mask_q)));  // R10
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_pulse |=> status_q[BIT_RX_OVF]);  // R8
  AST_UDF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[BIT_TX_UDF] && !(wr_status && reg_wdata[BIT_TX_UDF])) |=> status_q[BIT_TX_UDF]);  // R8
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arm |=> ((mask_q & $past(reg_wdata[IRQ_W-1:0]) & IRQ_DEFINED) == ($past(reg_wdata[IRQ_W-1:0]) & IRQ_DEFINED)));  // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disarm |=> ((mask_q & $past(reg_wdata[IRQ_W-1:0])) == '0));  // R4
  AST_TX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level >= CNT_W'(FIFO_DEPTH)) |=> status_q[BIT_TX_FULL]);  // R6
endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .tx_level    (tx_level),
  .rx_ovf_pulse(rx_ovf_pulse),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .irq         (irq)
);

// File: tb/flash_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_irq_ctrl_tb_top;
  localparam int DEPTH = 40;
  localparam int CW    = 6;
  localparam logic [7:0] A_ST = 8'h04, A_EN = 8'h08, A_DIS = 8'h0C,
                         A_MK = 8'h10, A_TXW = 8'h28, A_RXW = 8'h2C;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr_en;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [CW-1:0] tx_level, rx_level;
  logic          rx_ovf_pulse, tx_udf_pulse;
  logic          irq;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  flash_irq_ctrl #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
    .rx_level(rx_level), .rx_ovf_pulse(rx_ovf_pulse), .tx_udf_pulse(tx_udf_pulse),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_level = '0; rx_level = '0; rx_ovf_pulse = 1'b0; tx_udf_pulse = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (5) tick();

    // R1 reset state (empty TX FIFO with watermark 1 shows bit 2 only)
    rd(A_MK, v);  check("R1 mask", v, 32'h0);
    rd(A_ST, v);  check("R1 status", v, 32'h04);
    rd(A_TXW, v); check("R1 tx wm", v, 32'd1);
    rd(A_RXW, v); check("R1 rx wm", v, 32'd32);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_EN, v);  check("R2 enable reads 0", v, 32'h0);
    rd(A_DIS, v); check("R2 disable reads 0", v, 32'h0);
    tick();

    // R11 watermark readback
    wr(A_TXW, 32'hFFFF_FFE5); rd(A_TXW, v); check("R11 tx wm", v, 32'h25);
    wr(A_RXW, 32'h0000_0107); rd(A_RXW, v); check("R11 rx wm", v, 32'h07);

    // R5 R6 TX sweep, RX side kept quiet
    rx_level = '0; wr(A_RXW, 32'd32);
    for (int thr = 0; thr <= DEPTH + 1; thr++) begin
      wr(A_TXW, thr);
      for (int lvl = 0; lvl <= DEPTH; lvl++) begin
        logic [31:0] e;
        tx_level = CW'(lvl);
        wr(A_ST, 32'hFFFF_FFFF);
        e = 0;
        e[2] = (lvl < thr);
        e[3] = (lvl >= DEPTH);
        rd(A_ST, v);
        check("R5 R6 R9 tx sweep", v, e);
      end
    end

    // R6 R7 RX sweep, TX side kept quiet
    tx_level = CW'(5); wr(A_TXW, 32'd1);
    for (int thr = 0; thr <= DEPTH + 1; thr++) begin
      wr(A_RXW, thr);
      for (int lvl = 0; lvl <= DEPTH; lvl++) begin
        logic [31:0] e;
        rx_level = CW'(lvl);
        wr(A_ST, 32'hFFFF_FFFF);
        e = 0;
        e[4] = (lvl >= thr);
        e[5] = (lvl >= DEPTH);
        rd(A_ST, v);
        check("R6 R7 R9 rx sweep", v, e);
      end
    end

    // R3 R4 mask patterns
    for (int p = 0; p < 128; p++) begin
      wr(A_DIS, 32'hFFFF_FFFF);
      wr(A_EN, p);
      rd(A_MK, v); check("R3 arm pattern", v, p & 32'h7D);
      wr(A_EN, 32'h7F);
      wr(A_DIS, p);
      rd(A_MK, v); check("R4 disarm pattern", v, 32'h7D & ~p);
    end
    wr(A_DIS, 32'hFFFF_FFFF);

    // R8 sticky event bits
    rx_level = '0; wr(A_RXW, 32'd32);
    wr(A_ST, 32'h7F);
    rd(A_ST, v); check("R8 quiet start", v, 32'h0);
    rx_ovf_pulse = 1'b1; tick(); rx_ovf_pulse = 1'b0;
    repeat (3) tick();
    rd(A_ST, v); check("R8 overflow held", v, 32'h01);
    wr(A_ST, 32'h40);
    rd(A_ST, v); check("R8 other clear leaves bit0", v, 32'h01);
    wr(A_ST, 32'h01);
    rd(A_ST, v); check("R8 bit0 cleared", v, 32'h0);
    tx_udf_pulse = 1'b1; wr(A_ST, 32'h40); tx_udf_pulse = 1'b0;
    rd(A_ST, v); check("R8 pulse beats clear", v, 32'h40);
    wr(A_ST, 32'h40);
    rd(A_ST, v); check("R8 underflow cleared", v, 32'h0);

    // R9 level re-assert and latching
    rx_level = CW'(DEPTH); tick(); tick();
    wr(A_ST, 32'h30);
    rd(A_ST, v); check("R9 level re-asserts", v, 32'h30);
    rx_level = '0; tick(); tick();
    rd(A_ST, v); check("R9 level latched", v, 32'h30);
    wr(A_ST, 32'h30);
    rd(A_ST, v); check("R9 level cleared", v, 32'h0);

    // R10 interrupt per bit, one cycle behind mask
    wr(A_TXW, 32'd41); tx_level = CW'(DEPTH);
    wr(A_RXW, 32'd1);  rx_level = CW'(DEPTH);
    rx_ovf_pulse = 1'b1; tx_udf_pulse = 1'b1; tick();
    rx_ovf_pulse = 1'b0; tx_udf_pulse = 1'b0; tick();
    rd(A_ST, v); check("R10 all status set", v, 32'h7D);
    for (int b = 0; b < 7; b++) begin
      logic ex;
      ex = (b != 1);
      wr(A_DIS, 32'hFFFF_FFFF);
      tick();
      check("R10 irq low with empty mask", {31'b0, irq}, 32'h0);
      wr(A_EN, 32'h1 << b);
      check("R10 irq lags mask", {31'b0, irq}, 32'h0);
      tick();
      check("R10 irq per bit", {31'b0, irq}, {31'b0, ex});
    end
    wr(A_DIS, 32'hFFFF_FFFF);
    check("R10 irq holds one cycle", {31'b0, irq}, 32'h1);
    tick();
    check("R10 irq drops", {31'b0, irq}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule